// File: doc/BRIEF.md
# Column Event Address Serializer

This block sits at the foot of one pixel column and turns the raw per-pixel comparator bits into a stream of row addresses. Each pixel keeps a one-bit copy of its comparator result from the last capture; a pixel raises an event when its present comparator bit differs from that stored copy. Across a frame the stored copy follows the comparator, so a pixel whose voltage crosses the falling ramp reports exactly once.

When the capture enable is high and no earlier batch is still draining, every current event is loaded into a pending set at once. The block then gives out one row address per clock, lowest row first, each marked by a valid pulse. While the set is draining, a hold flag tells the ramp counter to stay where it is. A capture request that arrives while a batch is draining is not taken. The comparator bits involved are left untouched, so those events are taken at the next capture after the set is empty.

Top module: `col_event_encoder`

## Requirements
- R1: A pixel's event is the exclusive-OR of its present comparator bit and its stored bit. When a capture is taken, the stored bits copy the comparator bits. A pixel whose comparator stays high therefore gives no second event.
- R2: The stored bits change only on a clock edge where cap_en_i is high and the encoder is idle. A comparator pulse that starts and ends while cap_en_i is low yields no event.
- R3: Reset (rst_n low, asynchronous) clears all stored bits and the pending set, and drives valid_o=0, addr_o=0 and hold_o=0. After reset, a pixel whose comparator is still high fires again.
- R4: Events captured on the same edge are emitted one per clock, on consecutive clocks, in strictly ascending row index.
- R5: addr_o is the binary row index, 0 to N_PIX-1 (0 to 119 by default, 7 bits). Rows 0 and N_PIX-1 are both reachable.
- R6: On any clock where no address is being emitted, valid_o is 0 and addr_o is 0.
- R7: The first address appears on the clock after the capturing edge. hold_o is high from the capturing edge through the clock that shows the last address. A single event holds for two clocks, with valid_o high on the second.
- R8: A capture request made while a batch is draining is ignored. Events present at that time are emitted after a later capture taken once the encoder is idle.
- R9: A capture with no differing pixel leaves the encoder idle, with hold_o and valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rst_n | input | 1 | Asynchronous active-low reset, shared with the ramp counter |
| cmp_i | input | N_PIX | Latched comparator bit of each pixel, row 0 in bit 0 |
| cap_en_i | input | 1 | Gated event-capture enable (counter done AND delayed comparator clock) |
| addr_o | output | ADDR_W | Row index of the emitted event |
| valid_o | output | 1 | High on clocks that carry an address |
| hold_o | output | 1 | Stall request to the ramp counter while a batch is pending or shown |

## Verification
The assertions assume that cmp_i and cap_en_i are synchronous to clk and settle before each rising edge. The ordering check also relies on two batches never sitting back to back without an idle clock between them, which the capture-only-when-idle rule guarantees. The stimulus changes inputs only on the falling edge. It includes captures with no new pixels, comparator pulses that come and go while capture is off, capture requests issued during a drain, and a full column in which every row fires together. A behavioural model built from a queue is compared against valid, address and hold on every clock.

// File: rtl/col_enc_pkg.sv
package col_enc_pkg;
    typedef enum logic {
        ENC_IDLE = 1'b0,
        ENC_RUN  = 1'b1
    } enc_state_e;
endpackage

// File: rtl/pixel_change_detect.sv
module pixel_change_detect #(
    parameter int N_PIX = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIX-1:0] cmp_i,
    input  logic             upd_i,
    output logic [N_PIX-1:0] evt_o
);
    logic [N_PIX-1:0] prev_q;

    for (genvar g = 0; g < N_PIX; g++) begin : g_cell
        logic prev_d;
        always_comb prev_d = upd_i ? cmp_i[g] : prev_q[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= prev_d;
        end
        assign evt_o[g] = cmp_i[g] ^ prev_q[g];
    end

    // R2: stored bits never move without an update strobe
    p_prev_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(prev_q));
endmodule

// File: rtl/lowest_bit_pick.sv
module lowest_bit_pick #(
    parameter int N_PIX  = 120,
    parameter int ADDR_W = $clog2(N_PIX)
) (
    input  logic [N_PIX-1:0]  req_i,
    output logic [N_PIX-1:0]  sel_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic              any_o
);
    always_comb begin
        logic found;
        found = 1'b0;
        sel_o = '0;
        idx_o = '0;
        for (int i = 0; i < N_PIX; i++) begin
            if (req_i[i] && !found) begin
                found    = 1'b1;
                sel_o[i] = 1'b1;
                idx_o    = ADDR_W'(i);
            end
        end
        any_o = found;
    end

    // R4: at most one row granted at a time
    always_comb p_one_grant_r4: assert ($onehot0(sel_o));
endmodule

// File: rtl/col_event_encoder.sv
module col_event_encoder
    import col_enc_pkg::*;
#(
    parameter int N_PIX  = 120,
    parameter int ADDR_W = $clog2(N_PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIX-1:0]  cmp_i,
    input  logic              cap_en_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              hold_o
);
    typedef struct packed {
        enc_state_e        state;
        logic [N_PIX-1:0]  pend;
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } enc_regs_t;

    localparam enc_regs_t REGS_RST = '{state: ENC_IDLE, pend: '0, addr: '0, valid: 1'b0};

    enc_regs_t r_q, r_d;
    logic [N_PIX-1:0]  evt;
    logic [N_PIX-1:0]  pick_sel;
    logic [ADDR_W-1:0] pick_idx;
    logic              pick_any;
    logic              take_cap;

    assign take_cap = cap_en_i && (r_q.state == ENC_IDLE);

    pixel_change_detect #(.N_PIX(N_PIX)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .cmp_i (cmp_i),
        .upd_i (take_cap),
        .evt_o (evt)
    );

    lowest_bit_pick #(.N_PIX(N_PIX), .ADDR_W(ADDR_W)) u_pick (
        .req_i (r_q.pend),
        .sel_o (pick_sel),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.addr  = '0;
        unique case (r_q.state)
            ENC_RUN: begin
                r_d.valid = pick_any;
                r_d.addr  = pick_idx;
                r_d.pend  = r_q.pend & ~pick_sel;
                if ((r_q.pend & ~pick_sel) == '0) r_d.state = ENC_IDLE;
            end
            default: begin
                if (take_cap && (evt != '0)) begin
                    r_d.pend  = evt;
                    r_d.state = ENC_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign addr_o  = r_q.addr;
    assign valid_o = r_q.valid;
    assign hold_o  = (r_q.state == ENC_RUN) || r_q.valid;

    // R5: emitted index stays inside the column
    p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(addr_o) < N_PIX));
    // R6: quiet address when nothing is shown
    p_idle_addr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (addr_o == '0));
    // R4: consecutive addresses strictly ascend
    p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (addr_o > $past(addr_o)));
    // R7: a non-empty pending set always yields an address next clock
    p_drain_each_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend != '0) |=> valid_o);
    // R8: no new batch is loaded while one is pending
    p_no_reload_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ENC_RUN) |=> ((r_q.pend & ~$past(r_q.pend)) == '0));
endmodule

// File: tb/sim_col_event_encoder.sv
`timescale 1ns/1ps
module sim_col_event_encoder;
    localparam int N  = 120;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cmp = '0;
    logic          cap = 1'b0;
    logic [AW-1:0] addr;
    logic          valid;
    logic          hold;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference
    int   q[$];
    bit   m_prev[N];
    bit   m_valid;
    int   m_addr;

    always #2 clk = ~clk;

    col_event_encoder #(.N_PIX(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .cap_en_i(cap),
        .addr_o(addr), .valid_o(valid), .hold_o(hold)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (q.size() > 0) begin
            m_valid = 1'b1;
            m_addr  = q.pop_front();
        end else begin
            m_valid = 1'b0;
            m_addr  = 0;
            if (cap) begin
                for (int i = 0; i < N; i++) begin
                    if (cmp[i] != m_prev[i]) q.push_back(i);
                    m_prev[i] = cmp[i];
                end
            end
        end
    endtask

    task automatic compare(string tag);
        check(tag, "valid", int'(valid), int'(m_valid));
        check(tag, "addr", int'(addr), m_addr);
        check(tag, "hold", int'(hold), int'((q.size() > 0) || m_valid));
    endtask

    task automatic step(input logic [N-1:0] c, input logic e, input string tag);
        cmp = c;
        cap = e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cap   = 1'b0;
        q.delete();
        for (int i = 0; i < N; i++) m_prev[i] = 1'b0;
        m_valid = 1'b0;
        m_addr  = 0;
        @(negedge clk);
        check("R3", "valid in reset", int'(valid), 0);
        check("R3", "addr in reset", int'(addr), 0);
        check("R3", "hold in reset", int'(hold), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [N-1:0] v;
        do_reset();

        // R7 R5: single event at row 5
        v = '0; v[5] = 1'b1;
        step(v, 1'b1, "R7");
        for (int k = 0; k < 3; k++) step(v, 1'b0, "R7");

        // R1 R9: comparator stays high, capture gives no new event
        step(v, 1'b1, "R1");
        for (int k = 0; k < 2; k++) step(v, 1'b0, "R9");

        // R2: pulse while capture off leaves no trace
        v[20] = 1'b1;
        step(v, 1'b0, "R2");
        v[20] = 1'b0;
        step(v, 1'b0, "R2");
        step(v, 1'b1, "R2");
        step(v, 1'b0, "R2");

        // R4 R8: seven rows together, capture held high, extra row arrives mid-drain
        v[3] = 1'b1; v[10] = 1'b1; v[40] = 1'b1; v[64] = 1'b1;
        v[100] = 1'b1; v[118] = 1'b1; v[119] = 1'b1;
        step(v, 1'b1, "R4");
        for (int k = 0; k < 3; k++) step(v, 1'b1, "R4");
        v[50] = 1'b1;
        for (int k = 0; k < 8; k++) step(v, 1'b1, "R8");
        for (int k = 0; k < 3; k++) step(v, 1'b0, "R8");

        // R6: idle stretch
        for (int k = 0; k < 4; k++) step(v, 1'b0, "R6");

        // R3: reset mid-frame; rows still high fire again, plus full column (R5)
        do_reset();
        v = '1;
        step(v, 1'b1, "R3");
        for (int k = 0; k < N + 4; k++) step(v, 1'b0, "R5");

        // R9: capture with nothing new
        step(v, 1'b1, "R9");
        step(v, 1'b0, "R9");

        // R1: falling bit also differs from stored copy
        v[0] = 1'b0;
        step(v, 1'b1, "R1");
        for (int k = 0; k < 3; k++) step(v, 1'b0, "R1");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule